// File: doc/BRIEF.md
# Linear Flash Read Line-Fill Sequencer

This block sits between a memory-mapped read port and a byte-serial flash transfer engine. Each 32-bit read names a word inside one of several flash chips. The block holds one 1 KB line of flash contents. When the requested word falls inside that line, the word is returned straight from the line store and no serial traffic is needed.

On a miss, the line that contains the requested word is refilled before the read is answered. The block lowers the select line of the chip that the upper address bits name. It sends a command header made of an instruction byte, three address bytes (most significant first), an optional mode byte and a programmable count of zero dummy bytes. The bytes received while the header goes out are dropped. The block then clocks 1024 zero bytes through the engine and packs the received bytes into 256 words in the chosen byte order. It raises every select line, records the new line tag and finally answers the stalled read.

The header settings are held in a small configuration register. Its reset state is instruction 0xEB, mode byte 0xA0 enabled, and two dummy bytes.

Top module: `lflash_line_seq`

## Requirements
- R1: After reset all chip selects are high, no serial transfer is requested and no read is acknowledged. The configuration resets to instruction 0xEB, mode byte enabled with value 0xA0, and 2 dummy bytes.
- R2: The line store starts empty, so the first read after reset always causes a line fill.
- R3: A read whose word address has the same upper bits as the stored line tag (everything above the 8-bit word index) is a hit. The stored word is acknowledged one cycle after the request is seen, with no serial transfer.
- R4: On a miss the chip index is `rd_word_addr[23:22]` (the two bits above the 24-bit flash byte address). Only that chip's active-low select is low for the whole fill, and at most one select is ever low.
- R5: The header starts with the configured instruction byte, followed by the flash address of the line base as bits 23:16, then 15:8, then 7:0 (always zero for a line base).
- R6: When the mode-enable setting is 1, the configured mode byte is sent right after the address. When it is 0, no mode byte is sent.
- R7: The dummy-count setting (0 to 7) gives the number of zero bytes sent after the address and mode bytes.
- R8: After the header, exactly 1024 transfers are made, each sending 0x00. Bytes received during the header never reach the line store.
- R9: Received fill bytes are packed per word in arrival order. With `endian_big`=0 the first byte lands in bits 7:0 and the fourth in bits 31:24. With `endian_big`=1 the first byte lands in bits 31:24.
- R10: A missing read gets no acknowledge until the full fill is done. The acknowledge is a one-cycle pulse and is given only to a pending request.
- R11: At the end of a fill all selects go high before the acknowledge, and the filled line becomes the stored tag.
- R12: While a transfer is requested and not yet completed, the request and its byte stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the header settings |
| cfg_instr | input | 8 | Instruction byte to store |
| cfg_mode_val | input | 8 | Mode byte to store |
| cfg_mode_en | input | 1 | Mode byte enable to store |
| cfg_dummy | input | 3 | Dummy byte count to store |
| endian_big | input | 1 | Byte order used when packing fill words |
| rd_req | input | 1 | Read request, held until acknowledged |
| rd_word_addr | input | 24 | Word address: chip index in bits 23:22, flash word address below |
| rd_ready | output | 1 | One-cycle read acknowledge |
| rd_data | output | 32 | Read data, valid with `rd_ready` |
| xfer_valid | output | 1 | Serial byte transfer request |
| xfer_tx | output | 8 | Byte to send |
| xfer_done | input | 1 | Transfer completed; `xfer_rx` valid |
| xfer_rx | input | 8 | Byte received in the completed transfer |
| cs_n | output | 4 | Active-low chip selects |

## Verification
The assertions check the select and handshake rules on every cycle:
- at most one select is low;
- transfers happen only under a select;
- the byte is held until the engine completes it;
- the acknowledge is a single pulse with every select high.

Only the bench's scenarios can show that the header bytes, their order and their count follow the settings, that exactly 1024 zero bytes are fetched, and that words come back in the selected byte order. The scenarios also cover the line-boundary hit and miss decision and the choice of chip. A flash model in the bench decodes each header and serves address-dependent data, so a wrong address or order shows up as wrong read data.

// File: rtl/lflash_pkg.sv
package lflash_pkg;

    localparam int HCNT_W = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HDR  = 2'd1,
        ST_FILL = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic [7:0] instr;
        logic [7:0] mode_val;
        logic       mode_en;
        logic [2:0] dummy;
    } hdr_cfg_t;

    localparam hdr_cfg_t HDR_CFG_RST = '{instr: 8'hEB, mode_val: 8'hA0, mode_en: 1'b1, dummy: 3'd2};

endpackage

// File: rtl/lf_hdr_mux.sv
module lf_hdr_mux
    import lflash_pkg::*;
#(
    parameter int FLASH_AW = 24
) (
    input  hdr_cfg_t            cfg,
    input  logic [FLASH_AW-1:0] base,
    input  logic [HCNT_W-1:0]   idx,
    output logic [7:0]          hdr_byte,
    output logic                hdr_last
);
    logic [HCNT_W-1:0] hdr_len;

    always_comb begin
        hdr_len  = HCNT_W'(4) + HCNT_W'(cfg.mode_en) + HCNT_W'(cfg.dummy);
        hdr_last = (idx == hdr_len - HCNT_W'(1));
        unique case (idx)
            HCNT_W'(0): hdr_byte = cfg.instr;
            HCNT_W'(1): hdr_byte = base[23:16];
            HCNT_W'(2): hdr_byte = base[15:8];
            HCNT_W'(3): hdr_byte = base[7:0];
            HCNT_W'(4): hdr_byte = cfg.mode_en ? cfg.mode_val : 8'h00;
            default:    hdr_byte = 8'h00;
        endcase
    end
endmodule

// File: rtl/lf_word_pack.sv
module lf_word_pack (
    input  logic [23:0] prev_bytes,
    input  logic [7:0]  new_byte,
    input  logic        big,
    output logic [31:0] word
);
    logic [31:0] arrival;
    logic [31:0] swapped;

    assign arrival = {prev_bytes, new_byte};

    for (genvar k = 0; k < 4; k++) begin : g_lane
        assign swapped[8*k +: 8] = arrival[8*(3-k) +: 8];
    end

    assign word = big ? arrival : swapped;
endmodule

// File: rtl/lf_line_buf.sv
module lf_line_buf #(
    parameter int WIDX_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [WIDX_W-1:0] waddr,
    input  logic [31:0]       wdata,
    input  logic [WIDX_W-1:0] raddr,
    output logic [31:0]       rdata
);
    localparam int WORDS = 2 ** WIDX_W;

    logic [31:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/lflash_line_seq.sv
module lflash_line_seq
    import lflash_pkg::*;
#(
    parameter int FLASH_AW = 24,
    parameter int CHIP_W   = 2,
    parameter int LINE_W   = 10
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  logic [7:0]                    cfg_instr,
    input  logic [7:0]                    cfg_mode_val,
    input  logic                          cfg_mode_en,
    input  logic [2:0]                    cfg_dummy,
    input  logic                          endian_big,
    input  logic                          rd_req,
    input  logic [FLASH_AW+CHIP_W-3:0]    rd_word_addr,
    output logic                          rd_ready,
    output logic [31:0]                   rd_data,
    output logic                          xfer_valid,
    output logic [7:0]                    xfer_tx,
    input  logic                          xfer_done,
    input  logic [7:0]                    xfer_rx,
    output logic [(2**CHIP_W)-1:0]        cs_n
);
    localparam int ADDR_W = FLASH_AW + CHIP_W;
    localparam int WA_W   = ADDR_W - 2;
    localparam int WIDX_W = LINE_W - 2;
    localparam int TAG_W  = ADDR_W - LINE_W;
    localparam int NUM_CS = 2 ** CHIP_W;

    typedef struct packed {
        seq_state_e        st;
        logic              valid;
        logic [TAG_W-1:0]  tag;
        logic [HCNT_W-1:0] hcnt;
        logic [LINE_W-1:0] bcnt;
        logic [23:0]       pack;
        logic              rdy;
        logic [31:0]       rdata;
        hdr_cfg_t          cfg;
    } seq_reg_t;

    seq_reg_t q, d;

    logic [TAG_W-1:0]    req_tag;
    logic                hit;
    logic [CHIP_W-1:0]   chip;
    logic [FLASH_AW-1:0] line_base;
    logic [7:0]          hdr_byte;
    logic                hdr_last;
    logic [31:0]         packed_word;
    logic [31:0]         buf_rdata;
    logic                buf_we;

    assign req_tag   = rd_word_addr[WA_W-1:WIDX_W];
    assign hit       = q.valid && (req_tag == q.tag);
    assign chip      = q.tag[TAG_W-1 -: CHIP_W];
    assign line_base = {q.tag[FLASH_AW-LINE_W-1:0], {LINE_W{1'b0}}};

    lf_hdr_mux #(.FLASH_AW(FLASH_AW)) u_hdr (
        .cfg      (q.cfg),
        .base     (line_base),
        .idx      (q.hcnt),
        .hdr_byte (hdr_byte),
        .hdr_last (hdr_last)
    );

    lf_word_pack u_pack (
        .prev_bytes (q.pack),
        .new_byte   (xfer_rx),
        .big        (endian_big),
        .word       (packed_word)
    );

    lf_line_buf #(.WIDX_W(WIDX_W)) u_buf (
        .clk   (clk),
        .we    (buf_we),
        .waddr (q.bcnt[LINE_W-1:2]),
        .wdata (packed_word),
        .raddr (rd_word_addr[WIDX_W-1:0]),
        .rdata (buf_rdata)
    );

    always_comb begin
        d          = q;
        d.rdy      = 1'b0;
        buf_we     = 1'b0;
        xfer_valid = 1'b0;
        xfer_tx    = 8'h00;
        if (cfg_we) begin
            d.cfg = '{instr: cfg_instr, mode_val: cfg_mode_val,
                      mode_en: cfg_mode_en, dummy: cfg_dummy};
        end
        unique case (q.st)
            ST_IDLE: begin
                if (rd_req && !q.rdy) begin
                    if (hit) begin
                        d.rdy   = 1'b1;
                        d.rdata = buf_rdata;
                    end else begin
                        d.tag   = req_tag;
                        d.valid = 1'b0;
                        d.hcnt  = '0;
                        d.st    = ST_HDR;
                    end
                end
            end
            ST_HDR: begin
                xfer_valid = 1'b1;
                xfer_tx    = hdr_byte;
                if (xfer_done) begin
                    if (hdr_last) begin
                        d.st   = ST_FILL;
                        d.bcnt = '0;
                    end else begin
                        d.hcnt = q.hcnt + 1'b1;
                    end
                end
            end
            ST_FILL: begin
                xfer_valid = 1'b1;
                if (xfer_done) begin
                    d.pack = {q.pack[15:0], xfer_rx};
                    d.bcnt = q.bcnt + 1'b1;
                    buf_we = &q.bcnt[1:0];
                    if (&q.bcnt) begin
                        d.st    = ST_IDLE;
                        d.valid = 1'b1;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
            q.cfg   <= HDR_CFG_RST;
        end else begin
            q <= d;
        end
    end

    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
        assign cs_n[g] = !((q.st != ST_IDLE) && (chip == CHIP_W'(g)));
    end

    assign rd_ready = q.rdy;
    assign rd_data  = q.rdata;
endmodule

// File: rtl/lf_seq_chk.sv
module lf_seq_chk #(
    parameter int NUM_CS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_req,
    input logic              rd_ready,
    input logic              xfer_valid,
    input logic              xfer_done,
    input logic [7:0]        xfer_tx,
    input logic [NUM_CS-1:0] cs_n
);
    assert_one_cs_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~cs_n) <= 1);

    assert_xfer_under_cs_R4: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid |-> !(&cs_n));

    assert_tx_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid && !xfer_done) |=> (xfer_valid && $stable(xfer_tx)));

    assert_ack_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ready |=> !rd_ready);

    assert_ack_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ready |-> $past(rd_req));

    assert_ack_cs_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ready |-> (&cs_n && !xfer_valid));
endmodule

bind lflash_line_seq lf_seq_chk #(.NUM_CS(2 ** CHIP_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_req     (rd_req),
    .rd_ready   (rd_ready),
    .xfer_valid (xfer_valid),
    .xfer_done  (xfer_done),
    .xfer_tx    (xfer_tx),
    .cs_n       (cs_n)
);

// File: tb/lflash_line_seq_tb_top.sv
`timescale 1ns/1ps
module lflash_line_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_instr = 8'h00;
    logic [7:0]  cfg_mode_val = 8'h00;
    logic        cfg_mode_en = 1'b0;
    logic [2:0]  cfg_dummy = 3'd0;
    logic        endian_big = 1'b0;
    logic        rd_req = 1'b0;
    logic [23:0] rd_word_addr = '0;
    logic        rd_ready;
    logic [31:0] rd_data;
    logic        xfer_valid;
    logic [7:0]  xfer_tx;
    logic        xfer_done = 1'b0;
    logic [7:0]  xfer_rx = 8'h00;
    logic [3:0]  cs_n;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    // bench copy of the header settings
    logic [7:0] s_instr = 8'hEB;
    logic [7:0] s_mode  = 8'hA0;
    int         s_mode_en = 1;
    int         s_dummy = 2;

    // flash model state
    logic [7:0] hdr_seen [16];
    int  pos = 0;
    int  nz_data = 0;
    int  total = 0;
    int  sess_chip = -1;
    bit  in_sess = 0;
    int  dly = 0;

    bit          b_valid = 0;
    logic [15:0] b_tag = '0;

    always #2 clk = ~clk;

    lflash_line_seq dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_instr(cfg_instr),
        .cfg_mode_val(cfg_mode_val), .cfg_mode_en(cfg_mode_en), .cfg_dummy(cfg_dummy),
        .endian_big(endian_big), .rd_req(rd_req), .rd_word_addr(rd_word_addr),
        .rd_ready(rd_ready), .rd_data(rd_data), .xfer_valid(xfer_valid),
        .xfer_tx(xfer_tx), .xfer_done(xfer_done), .xfer_rx(xfer_rx), .cs_n(cs_n)
    );

    function automatic logic [7:0] fbyte(input int chip, input logic [23:0] fa);
        return 8'(fa[7:0] * 8'd29) ^ fa[15:8] ^ fa[23:16] ^ 8'(chip * 8'h35) ^ 8'h5A;
    endfunction

    function automatic logic [31:0] exp_word(input int chip, input logic [23:0] fa, input bit big);
        logic [23:0] a0 = {fa[23:2], 2'b00};
        logic [7:0] b0 = fbyte(chip, a0);
        logic [7:0] b1 = fbyte(chip, a0 + 24'd1);
        logic [7:0] b2 = fbyte(chip, a0 + 24'd2);
        logic [7:0] b3 = fbyte(chip, a0 + 24'd3);
        return big ? {b0, b1, b2, b3} : {b3, b2, b1, b0};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // serial flash model, driven at negative edges
    initial begin
        forever begin
            logic [7:0] rx;
            int hlen;
            @(negedge clk);
            xfer_done = 1'b0;
            if (&cs_n) begin
                in_sess = 0;
            end else begin
                if (!in_sess) begin
                    in_sess = 1; pos = 0; nz_data = 0;
                    for (int i = 0; i < 4; i++) if (!cs_n[i]) sess_chip = i;
                end
                if (xfer_valid) begin
                    if (dly > 0) begin
                        dly--;
                    end else begin
                        hlen = 4 + s_mode_en + s_dummy;
                        if (pos < hlen) begin
                            if (pos < 16) hdr_seen[pos] = xfer_tx;
                            rx = 8'($urandom);
                        end else begin
                            if (xfer_tx != 8'h00) nz_data++;
                            rx = fbyte(sess_chip, {hdr_seen[1], hdr_seen[2], hdr_seen[3]} + 24'(pos - hlen));
                        end
                        xfer_rx = rx;
                        xfer_done = 1'b1;
                        pos++;
                        total++;
                        dly = int'($urandom % 2);
                    end
                end
            end
        end
    end

    task automatic set_cfg(input logic [7:0] ins, input logic [7:0] mv, input int men, input int dm);
        @(negedge clk);
        cfg_instr = ins; cfg_mode_val = mv; cfg_mode_en = 1'(men); cfg_dummy = 3'(dm);
        cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
        s_instr = ins; s_mode = mv; s_mode_en = men; s_dummy = dm;
    endtask

    task automatic do_read(input int chip, input logic [23:0] fa);
        logic [15:0] line = {2'(chip), fa[23:10]};
        bit miss = !(b_valid && line == b_tag);
        int t0 = total;
        int waited = 0;
        int hlen = 4 + s_mode_en + s_dummy;
        logic [31:0] exp = exp_word(chip, fa, endian_big);
        rd_word_addr = {2'(chip), fa[23:2]};
        rd_req = 1'b1;
        do begin
            @(negedge clk);
            waited++;
        end while (!rd_ready && waited < 20000);
        chk(rd_ready, "R10", "ack arrives", 32'(rd_ready), 1);
        chk(&cs_n, "R11", "selects high at ack", 32'(cs_n), 32'hF);
        chk(rd_data == exp, "R9", "read data", rd_data, exp);
        rd_req = 1'b0;
        if (miss) begin
            chk(total - t0 == hlen + 1024, "R10", "transfers before ack", 32'(total - t0), 32'(hlen + 1024));
            chk(sess_chip == chip, "R4", "selected chip", 32'(sess_chip), 32'(chip));
            chk(hdr_seen[0] == s_instr, "R5", "instruction byte", 32'(hdr_seen[0]), 32'(s_instr));
            chk({hdr_seen[1], hdr_seen[2], hdr_seen[3]} == {fa[23:10], 10'd0}, "R5", "address bytes",
                32'({hdr_seen[1], hdr_seen[2], hdr_seen[3]}), 32'({fa[23:10], 10'd0}));
            if (s_mode_en != 0)
                chk(hdr_seen[4] == s_mode, "R6", "mode byte", 32'(hdr_seen[4]), 32'(s_mode));
            for (int i = 4 + s_mode_en; i < hlen; i++)
                chk(hdr_seen[i] == 8'h00, "R7", "dummy byte", 32'(hdr_seen[i]), 0);
            chk(nz_data == 0, "R8", "fill bytes zero", 32'(nz_data), 0);
            b_valid = 1;
            b_tag = line;
        end else begin
            chk(total == t0, "R3", "no transfer on hit", 32'(total - t0), 0);
            chk(waited == 1, "R3", "hit latency", 32'(waited), 1);
        end
        @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk(&cs_n, "R1", "reset selects", 32'(cs_n), 32'hF);
        chk(!xfer_valid, "R1", "reset transfer request", 32'(xfer_valid), 0);
        chk(!rd_ready, "R1", "reset ack", 32'(rd_ready), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(&cs_n && !xfer_valid, "R1", "idle after reset", 32'(cs_n), 32'hF);

        // R2 and R1: first read fills with reset header settings
        begin
            int t0 = total;
            do_read(0, 24'h000104);
            chk(total - t0 == 1031, "R2", "first read fills", 32'(total - t0), 1031);
            chk(hdr_seen[0] == 8'hEB && hdr_seen[4] == 8'hA0, "R1", "reset header",
                32'({hdr_seen[0], hdr_seen[4]}), 32'hEBA0);
        end
        // R3: hits across the line, last word boundary
        do_read(0, 24'h000000);
        do_read(0, 24'h0003FC);
        // boundary: next line misses
        do_read(0, 24'h000400);
        // R4: other chips
        do_read(2, 24'h123458);
        do_read(3, 24'hFFFFFC);
        do_read(3, 24'hFFFC00);
        // R6 R7: no mode byte, no dummies
        set_cfg(8'h0B, 8'h11, 0, 0);
        do_read(1, 24'h000800);
        // R6 R7: mode byte and 7 dummies
        set_cfg(8'h6B, 8'h5C, 1, 7);
        do_read(1, 24'h00F010);
        // R9: big byte order
        endian_big = 1'b1;
        do_read(2, 24'h0A0A0C);
        do_read(2, 24'h0A0BF0);
        endian_big = 1'b0;
        set_cfg(8'hEB, 8'hA0, 1, 2);
        // random mix over a small pool of lines
        for (int n = 0; n < 30; n++) begin
            int sel = int'($urandom % 3);
            int chip = (sel == 2) ? 1 : 0;
            logic [23:0] fa = (sel == 0) ? 24'h004000 : (sel == 1) ? 24'h004400 : 24'h7FFC00;
            fa[9:2] = 8'($urandom);
            do_read(chip, fa);
        end
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule